// File: doc/BRIEF.md
# Display Controller Command Register File

This block is the control front end of a small matrix display controller. It receives bytes that a host interface has already deserialised, each tagged with a data/command flag. A byte with the flag low is decoded as a command and updates the control register set: power state, addressing direction, instruction page, display mode, column and bank pointers, mirroring, temperature code, bias code, multiplex code, frame-rate code, partial-display enable and operating voltage code. A byte with the flag high is written to the display RAM write port at the current column/bank pointer, and the pointer then advances.

The active-low reset pin and a software reset command both reload the register defaults. Neither one touches the RAM. A memory-blank command walks the whole RAM with one zero write per clock and reports busy while it runs. A static strap input selects between the basic and the extended instruction set. While the power-down bit is set, the driver, bias, voltage-generator and oscillator enables are all held low.

Top module: `dcr_top`

## Requirements
- R1: After the reset pin is released, the registers hold these values: power-down = 1, vertical addressing = 0, page = 0, D = E = 0, mirror X/Y = 0, column = 0, bank = 0, temperature = 0, bias = 0, multiplex = 0, frame-rate code = 2'b01 (the 75 Hz setting), partial enable = 0, voltage code = 0, busy = 0.
- R2: While power-down is 1, drv_en, bias_en, vgen_en and osc_en are all 0. While it is 0, all four are 1.
- R3: A function-set command works in any page. Its encoding is 001P_VHH0: P is bit 4, V is bit 3 and the page is bits 2:1. In page 0, 00001D0E sets D (bit 2) and E (bit 0), 1xxx_xxxx sets the column to bits 6:0, and 010y_yyyy sets the bank to bits 4:0.
- R4: In page 1, 0000_01tt sets the temperature code, 0001_0bbb sets the bias code and 1vvv_vvvv sets the voltage code. In page 2 (extended set only), 0000_10xy sets mirror X/Y, 0000_01mm sets the multiplex code, 0001_00ff sets the frame-rate code and 0001_100p sets the partial enable.
- R5: With ext_mode low, a function-set command whose page bit 2 is 1 is ignored entirely, so page 2 and page 3 cannot be entered. Pages 0 and 1 remain usable.
- R6: A command byte that matches no encoding in the current page changes no register.
- R7: A data byte accepted while idle produces, in the same cycle, ram_we = 1, ram_x/ram_y equal to the current pointers and ram_wdata equal to the byte.
- R8: After each data write with V = 0, the column increments. From NUM_COLS-1 it returns to 0 and the bank increments (wrapping after NUM_BANKS-1). With V = 1, the bank increments. From NUM_BANKS-1 it returns to 0 and the column increments (wrapping).
- R9: Command 8'h02, in any page, reloads every register and both pointers to their R1 values.
- R10: Command 8'h03 raises busy on the next cycle. It then writes zero to every (column, bank) pair exactly once, column fastest, NUM_COLS*NUM_BANKS cycles in total. While busy, host bytes are ignored and the pointers and registers keep their values.
- R11: Asserting the reset pin clears busy and ram_we immediately, which aborts a blank walk or an incoming byte.
- R12: A set-column value ≥ NUM_COLS or a set-bank value ≥ NUM_BANKS is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode | input | 1 | Static strap: 1 = extended instruction set |
| rx_valid | input | 1 | Host byte valid this cycle |
| rx_dc | input | 1 | 1 = data byte, 0 = command byte |
| rx_byte | input | 8 | Host byte |
| busy | output | 1 | Memory-blank walk in progress |
| ram_we | output | 1 | RAM write enable |
| ram_x | output | 7 | RAM column address (host pointer when idle) |
| ram_y | output | 5 | RAM bank address (host pointer when idle) |
| ram_wdata | output | 8 | RAM write data |
| pd | output | 1 | Power-down bit |
| vaddr | output | 1 | Vertical addressing bit |
| hpage | output | 2 | Instruction page |
| disp_d | output | 1 | Display mode D bit |
| disp_e | output | 1 | Display mode E bit |
| mirror_x | output | 1 | Column mirror |
| mirror_y | output | 1 | Row mirror |
| tc | output | 2 | Temperature coefficient code |
| bias | output | 3 | Bias code |
| mux | output | 2 | Multiplex ratio code |
| frate | output | 2 | Frame-rate code |
| part_en | output | 1 | Partial display enable |
| vop | output | 7 | Operating voltage code |
| drv_en | output | 1 | Display driver enable |
| bias_en | output | 1 | Bias generator enable |
| vgen_en | output | 1 | Voltage generator enable |
| osc_en | output | 1 | Oscillator enable |

## Verification
The table walks command bytes through all four pages. It reuses one byte value, 0x85, in page 0 and in page 1, which shows that decoding depends on the page: the same byte moves the column pointer in one page and the voltage code in the other. An unknown byte in page 2 shows that unmatched opcodes are harmless. Directed data-write runs start next to the last column and the last bank in both addressing directions, which separates a wrap from a plain increment. A blank walk interleaved with host bytes shows that the walk is exact and that host bytes are blocked during it. Tests with the strap low and with out-of-range pointer values cover the cases where a command must be ignored.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

  localparam int X_W = 7;
  localparam int Y_W = 5;

  localparam logic [1:0] FRATE_75   = 2'b01;
  localparam logic [7:0] OP_SRESET  = 8'h02;
  localparam logic [7:0] OP_BLANK   = 8'h03;

  typedef enum logic [3:0] {
    CMD_NONE, CMD_FUNC, CMD_DMODE, CMD_SETX, CMD_SETY,
    CMD_TC, CMD_BIAS, CMD_VOP, CMD_MIRROR, CMD_MUX,
    CMD_FRATE, CMD_PART, CMD_SRESET, CMD_BLANK
  } cmd_e;

  typedef struct packed {
    logic       pd;
    logic       vaddr;
    logic [1:0] hpage;
    logic       disp_d;
    logic       disp_e;
    logic       mx;
    logic       my;
    logic [1:0] tc;
    logic [2:0] bias;
    logic [1:0] mux;
    logic [1:0] frate;
    logic       pe;
    logic [6:0] vop;
  } cfg_t;

  function automatic cfg_t cfg_reset();
    cfg_t c;
    c       = '0;
    c.pd    = 1'b1;
    c.frate = FRATE_75;
    return c;
  endfunction

endpackage

// File: rtl/dcr_decode.sv
module dcr_decode
  import dcr_pkg::*;
(
  input  logic       ext_mode,
  input  logic [1:0] hpage,
  input  logic [7:0] op,
  output cmd_e       kind
);

  always_comb begin
    kind = CMD_NONE;
    if (op == OP_SRESET) begin
      kind = CMD_SRESET;
    end else if (op == OP_BLANK) begin
      kind = CMD_BLANK;
    end else if (op[7:5] == 3'b001 && !op[0]) begin
      // page bit 2 reaches pages 2/3, extended set only
      kind = (op[2] && !ext_mode) ? CMD_NONE : CMD_FUNC;
    end else begin
      case (hpage)
        2'd0: begin
          if (op[7])                               kind = CMD_SETX;
          else if (op[7:5] == 3'b010)              kind = CMD_SETY;
          else if (op[7:3] == 5'b00001 && !op[1])  kind = CMD_DMODE;
        end
        2'd1: begin
          if (op[7])                               kind = CMD_VOP;
          else if (op[7:2] == 6'b000001)           kind = CMD_TC;
          else if (op[7:3] == 5'b00010)            kind = CMD_BIAS;
        end
        2'd2: begin
          if (ext_mode) begin
            if (op[7:2] == 6'b000010)              kind = CMD_MIRROR;
            else if (op[7:2] == 6'b000001)         kind = CMD_MUX;
            else if (op[7:2] == 6'b000100)         kind = CMD_FRATE;
            else if (op[7:1] == 7'b0001100)        kind = CMD_PART;
          end
        end
        default: kind = CMD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/dcr_regs.sv
module dcr_regs
  import dcr_pkg::*;
#(
  parameter int NUM_COLS  = 96,
  parameter int NUM_BANKS = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ext_mode,
  input  logic           cmd_v,
  input  cmd_e           kind,
  input  logic [6:0]     arg,
  input  logic           adv,
  output cfg_t           cfg,
  output logic [X_W-1:0] x_ptr,
  output logic [Y_W-1:0] y_ptr
);

  localparam logic [X_W-1:0] LAST_X = X_W'(NUM_COLS - 1);
  localparam logic [Y_W-1:0] LAST_Y = Y_W'(NUM_BANKS - 1);
  localparam logic [X_W:0]   COLS_L = (X_W+1)'(NUM_COLS);
  localparam logic [Y_W:0]   BANKS_L = (Y_W+1)'(NUM_BANKS);

  cfg_t           cfg_q, cfg_d;
  logic [X_W-1:0] x_q, x_d;
  logic [Y_W-1:0] y_q, y_d;

  always_comb begin
    cfg_d = cfg_q;
    x_d   = x_q;
    y_d   = y_q;
    if (adv) begin
      if (!cfg_q.vaddr) begin
        if (x_q == LAST_X) begin
          x_d = '0;
          y_d = (y_q == LAST_Y) ? '0 : y_q + 1'b1;
        end else begin
          x_d = x_q + 1'b1;
        end
      end else begin
        if (y_q == LAST_Y) begin
          y_d = '0;
          x_d = (x_q == LAST_X) ? '0 : x_q + 1'b1;
        end else begin
          y_d = y_q + 1'b1;
        end
      end
    end
    if (cmd_v) begin
      case (kind)
        CMD_FUNC: begin
          cfg_d.pd    = arg[4];
          cfg_d.vaddr = arg[3];
          cfg_d.hpage = arg[2:1];
        end
        CMD_DMODE: begin
          cfg_d.disp_d = arg[2];
          cfg_d.disp_e = arg[0];
        end
        CMD_SETX:   if ({1'b0, arg[6:0]} < COLS_L)  x_d = arg[6:0];
        CMD_SETY:   if ({1'b0, arg[4:0]} < BANKS_L) y_d = arg[4:0];
        CMD_TC:     cfg_d.tc    = arg[1:0];
        CMD_BIAS:   cfg_d.bias  = arg[2:0];
        CMD_VOP:    cfg_d.vop   = arg[6:0];
        CMD_MIRROR: begin
          cfg_d.mx = arg[1];
          cfg_d.my = arg[0];
        end
        CMD_MUX:    cfg_d.mux   = arg[1:0];
        CMD_FRATE:  cfg_d.frate = arg[1:0];
        CMD_PART:   cfg_d.pe    = arg[0];
        CMD_SRESET: begin
          cfg_d = cfg_reset();
          x_d   = '0;
          y_d   = '0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= cfg_reset();
      x_q   <= '0;
      y_q   <= '0;
    end else if (cmd_v || adv) begin
      cfg_q <= cfg_d;
      x_q   <= x_d;
      y_q   <= y_d;
    end
  end

  assign cfg   = cfg_q;
  assign x_ptr = x_q;
  assign y_ptr = y_q;

  assert_ptr_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, x_q} < COLS_L) && ({1'b0, y_q} < BANKS_L));

  assert_basic_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_mode |-> !cfg_q.hpage[1]);

endmodule

// File: rtl/dcr_blank.sv
module dcr_blank
  import dcr_pkg::*;
#(
  parameter int NUM_COLS  = 96,
  parameter int NUM_BANKS = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output logic           busy,
  output logic [X_W-1:0] wx,
  output logic [Y_W-1:0] wy
);

  localparam logic [X_W-1:0] LAST_X = X_W'(NUM_COLS - 1);
  localparam logic [Y_W-1:0] LAST_Y = Y_W'(NUM_BANKS - 1);

  logic           busy_q, busy_d;
  logic [X_W-1:0] wx_q, wx_d;
  logic [Y_W-1:0] wy_q, wy_d;

  always_comb begin
    busy_d = busy_q;
    wx_d   = wx_q;
    wy_d   = wy_q;
    if (busy_q) begin
      if (wx_q == LAST_X) begin
        wx_d = '0;
        if (wy_q == LAST_Y) begin
          busy_d = 1'b0;
          wy_d   = '0;
        end else begin
          wy_d = wy_q + 1'b1;
        end
      end else begin
        wx_d = wx_q + 1'b1;
      end
    end else if (start) begin
      busy_d = 1'b1;
      wx_d   = '0;
      wy_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wx_q   <= '0;
      wy_q   <= '0;
    end else if (busy_q || start) begin
      busy_q <= busy_d;
      wx_q   <= wx_d;
      wy_q   <= wy_d;
    end
  end

  assign busy = busy_q;
  assign wx   = wx_q;
  assign wy   = wy_q;

  assert_walk_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (wx_q <= LAST_X) && (wy_q <= LAST_Y));

  assert_walk_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wx_q == LAST_X && wy_q == LAST_Y) |=> !busy_q);

  assert_walk_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && start) |=> busy_q && wx_q == '0 && wy_q == '0);

endmodule

// File: rtl/dcr_top.sv
module dcr_top
  import dcr_pkg::*;
#(
  parameter int NUM_COLS  = 96,
  parameter int NUM_BANKS = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_mode,
  input  logic       rx_valid,
  input  logic       rx_dc,
  input  logic [7:0] rx_byte,
  output logic       busy,
  output logic       ram_we,
  output logic [6:0] ram_x,
  output logic [4:0] ram_y,
  output logic [7:0] ram_wdata,
  output logic       pd,
  output logic       vaddr,
  output logic [1:0] hpage,
  output logic       disp_d,
  output logic       disp_e,
  output logic       mirror_x,
  output logic       mirror_y,
  output logic [1:0] tc,
  output logic [2:0] bias,
  output logic [1:0] mux,
  output logic [1:0] frate,
  output logic       part_en,
  output logic [6:0] vop,
  output logic       drv_en,
  output logic       bias_en,
  output logic       vgen_en,
  output logic       osc_en
);

  localparam logic [X_W-1:0] LAST_X = X_W'(NUM_COLS - 1);

  logic [1:0]     rst_pipe;
  logic           rst_s;
  logic           acc, cmd_v, dat_v, blank_go;
  cmd_e           kind;
  cfg_t           cfg;
  logic [X_W-1:0] x_ptr, wx;
  logic [Y_W-1:0] y_ptr, wy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  assign acc      = rx_valid && rst_s && !busy;
  assign cmd_v    = acc && !rx_dc;
  assign dat_v    = acc && rx_dc;
  assign blank_go = cmd_v && (kind == CMD_BLANK);

  dcr_decode u_dec (
    .ext_mode (ext_mode),
    .hpage    (cfg.hpage),
    .op       (rx_byte),
    .kind     (kind)
  );

  dcr_regs #(.NUM_COLS(NUM_COLS), .NUM_BANKS(NUM_BANKS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_s),
    .ext_mode (ext_mode),
    .cmd_v    (cmd_v),
    .kind     (kind),
    .arg      (rx_byte[6:0]),
    .adv      (dat_v),
    .cfg      (cfg),
    .x_ptr    (x_ptr),
    .y_ptr    (y_ptr)
  );

  dcr_blank #(.NUM_COLS(NUM_COLS), .NUM_BANKS(NUM_BANKS)) u_blank (
    .clk   (clk),
    .rst_n (rst_s),
    .start (blank_go),
    .busy  (busy),
    .wx    (wx),
    .wy    (wy)
  );

  assign ram_we    = busy || dat_v;
  assign ram_x     = busy ? wx : x_ptr;
  assign ram_y     = busy ? wy : y_ptr;
  assign ram_wdata = busy ? 8'h00 : rx_byte;

  assign pd       = cfg.pd;
  assign vaddr    = cfg.vaddr;
  assign hpage    = cfg.hpage;
  assign disp_d   = cfg.disp_d;
  assign disp_e   = cfg.disp_e;
  assign mirror_x = cfg.mx;
  assign mirror_y = cfg.my;
  assign tc       = cfg.tc;
  assign bias     = cfg.bias;
  assign mux      = cfg.mux;
  assign frate    = cfg.frate;
  assign part_en  = cfg.pe;
  assign vop      = cfg.vop;
  assign drv_en   = !cfg.pd;
  assign bias_en  = !cfg.pd;
  assign vgen_en  = !cfg.pd;
  assign osc_en   = !cfg.pd;

  assert_busy_freeze_R10: assert property (@(posedge clk) disable iff (!rst_s)
    busy |=> $stable(cfg) && $stable(x_ptr) && $stable(y_ptr));

  assert_walk_zero_R10: assert property (@(posedge clk) disable iff (!rst_s)
    busy |-> ram_we && ram_wdata == 8'h00);

  assert_col_step_R8: assert property (@(posedge clk) disable iff (!rst_s)
    (dat_v && !cfg.vaddr && x_ptr != LAST_X) |=> x_ptr == $past(x_ptr) + 1'b1);

  assert_idle_write_R7: assert property (@(posedge clk) disable iff (!rst_s)
    (!busy && !(rx_valid && rx_dc)) |-> !ram_we);

endmodule

// File: tb/dcr_top_test.sv
module dcr_top_test;

  localparam int COLS  = 96;
  localparam int BANKS = 9;

  // selectors for the observed field
  localparam logic [3:0] S_X = 0, S_Y = 1, S_HP = 2, S_PDV = 3, S_DE = 4,
    S_TC = 5, S_BIAS = 6, S_VOP = 7, S_MIR = 8, S_MUX = 9, S_FR = 10,
    S_PE = 11, S_PWR = 12;

  localparam int NV = 18;
  // {dc, byte, selector, expected}
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 8'h20, S_PDV,  8'h00},
    {1'b0, 8'h0D, S_DE,   8'h03},
    {1'b0, 8'h85, S_X,    8'h05},
    {1'b0, 8'h43, S_Y,    8'h03},
    {1'b0, 8'h22, S_HP,   8'h01},
    {1'b0, 8'h06, S_TC,   8'h02},
    {1'b0, 8'h15, S_BIAS, 8'h05},
    {1'b0, 8'hC8, S_VOP,  8'h48},
    {1'b0, 8'h85, S_VOP,  8'h05},
    {1'b0, 8'h24, S_HP,   8'h02},
    {1'b0, 8'h0B, S_MIR,  8'h03},
    {1'b0, 8'h06, S_MUX,  8'h02},
    {1'b0, 8'h13, S_FR,   8'h03},
    {1'b0, 8'h19, S_PE,   8'h01},
    {1'b0, 8'h1F, S_FR,   8'h03},
    {1'b0, 8'h28, S_PDV,  8'h01},
    {1'b0, 8'h08, S_DE,   8'h00},
    {1'b0, 8'h30, S_PDV,  8'h02}
  };

  logic clk = 1'b0;
  logic rst_n, ext_mode, rx_valid, rx_dc;
  logic [7:0] rx_byte;
  logic busy, ram_we, pd, vaddr, disp_d, disp_e, mirror_x, mirror_y, part_en;
  logic drv_en, bias_en, vgen_en, osc_en;
  logic [6:0] ram_x, vop;
  logic [4:0] ram_y;
  logic [7:0] ram_wdata;
  logic [1:0] hpage, tc, mux, frate;
  logic [2:0] bias;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dcr_top #(.NUM_COLS(COLS), .NUM_BANKS(BANKS)) uut (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .rx_valid(rx_valid),
    .rx_dc(rx_dc), .rx_byte(rx_byte), .busy(busy), .ram_we(ram_we),
    .ram_x(ram_x), .ram_y(ram_y), .ram_wdata(ram_wdata), .pd(pd),
    .vaddr(vaddr), .hpage(hpage), .disp_d(disp_d), .disp_e(disp_e),
    .mirror_x(mirror_x), .mirror_y(mirror_y), .tc(tc), .bias(bias),
    .mux(mux), .frate(frate), .part_en(part_en), .vop(vop),
    .drv_en(drv_en), .bias_en(bias_en), .vgen_en(vgen_en), .osc_en(osc_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] obs(input logic [3:0] sel);
    case (sel)
      S_X:    return 32'(ram_x);
      S_Y:    return 32'(ram_y);
      S_HP:   return 32'(hpage);
      S_PDV:  return 32'({pd, vaddr});
      S_DE:   return 32'({disp_d, disp_e});
      S_TC:   return 32'(tc);
      S_BIAS: return 32'(bias);
      S_VOP:  return 32'(vop);
      S_MIR:  return 32'({mirror_x, mirror_y});
      S_MUX:  return 32'(mux);
      S_FR:   return 32'(frate);
      S_PE:   return 32'(part_en);
      S_PWR:  return 32'({drv_en, bias_en, vgen_en, osc_en});
      default: return 32'hDEAD;
    endcase
  endfunction

  task automatic do_reset();
    rst_n    = 1'b0;
    rx_valid = 1'b0;
    rx_dc    = 1'b0;
    rx_byte  = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic dc, input logic [7:0] b);
    rx_valid = 1'b1;
    rx_dc    = dc;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_dc    = 1'b0;
  endtask

  task automatic wr_chk(input logic [7:0] b, input int ex, input int ey, input string req);
    rx_valid = 1'b1;
    rx_dc    = 1'b1;
    rx_byte  = b;
    #1;
    chk({req, " we"}, 32'(ram_we), 1);
    chk({req, " x"}, 32'(ram_x), ex);
    chk({req, " y"}, 32'(ram_y), ey);
    chk({req, " data"}, 32'(ram_wdata), 32'(b));
    @(negedge clk);
    rx_valid = 1'b0;
    rx_dc    = 1'b0;
  endtask

  task automatic chk_defaults(input string req);
    chk({req, " pd/v"}, obs(S_PDV), 2);
    chk({req, " page"}, obs(S_HP), 0);
    chk({req, " D/E"}, obs(S_DE), 0);
    chk({req, " mirror"}, obs(S_MIR), 0);
    chk({req, " x"}, obs(S_X), 0);
    chk({req, " y"}, obs(S_Y), 0);
    chk({req, " tc/bias/mux"}, {tc, bias, mux}, 0);
    chk({req, " frate"}, obs(S_FR), 1);
    chk({req, " part"}, obs(S_PE), 0);
    chk({req, " vop"}, obs(S_VOP), 0);
    chk({req, " busy"}, 32'(busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    ext_mode = 1'b1;
    do_reset();
    chk_defaults("R1");
    chk("R2 powered down enables", obs(S_PWR), 0);

    // table of commands; R3 and R4 encodings, R6 for 0x1F in page 2
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][20], VEC[i][19:12]);
      chk($sformatf("R3 R4 R6 vector %0d", i), obs(VEC[i][11:8]), 32'(VEC[i][7:0]));
    end
    chk("R2 power-down enables off", obs(S_PWR), 0);
    send(1'b0, 8'h20);
    chk("R2 powered up enables on", obs(S_PWR), 4'hF);

    // R6: unknown byte in page 0, then page 3 accepts nothing
    send(1'b0, 8'h85);
    send(1'b0, 8'h01);
    chk("R6 page0 unknown keeps x", obs(S_X), 5);
    chk("R6 page0 unknown keeps vop", obs(S_VOP), 5);
    send(1'b0, 8'h26);
    send(1'b0, 8'h8A);
    send(1'b0, 8'h07);
    chk("R6 page3 keeps tc", obs(S_TC), 2);
    send(1'b0, 8'h20);
    chk("R6 page3 keeps x", obs(S_X), 5);

    // R9 software reset
    send(1'b0, 8'h02);
    chk_defaults("R9");

    // R7 / R8 horizontal wrap, R12 range
    send(1'b0, 8'hDE);
    send(1'b0, 8'h48);
    send(1'b0, 8'hE0);
    send(1'b0, 8'h49);
    chk("R12 x out of range ignored", obs(S_X), 94);
    chk("R12 y out of range ignored", obs(S_Y), 8);
    wr_chk(8'hA5, 94, 8, "R7");
    wr_chk(8'h3C, 95, 8, "R8 h step");
    wr_chk(8'h5A, 0, 0, "R8 h wrap");
    chk("R8 h after wrap x", obs(S_X), 1);

    // R8 vertical
    send(1'b0, 8'h28);
    send(1'b0, 8'h83);
    send(1'b0, 8'h47);
    wr_chk(8'h11, 3, 7, "R8 v");
    wr_chk(8'h22, 3, 8, "R8 v step");
    wr_chk(8'h33, 4, 0, "R8 v wrap");

    // R10 memory blank
    send(1'b0, 8'h20);
    send(1'b0, 8'h87);
    send(1'b0, 8'h42);
    send(1'b0, 8'h03);
    begin
      int n = 0, bad = 0, ex = 0, ey = 0;
      while (busy && n < 2000) begin
        if (!ram_we || ram_wdata !== 8'h00 || ram_x !== 7'(ex) || ram_y !== 5'(ey)) bad++;
        if (n == 20) begin rx_valid = 1'b1; rx_dc = 1'b1; rx_byte = 8'h77; end
        if (n == 22) begin rx_dc = 1'b0; rx_byte = 8'h30; end
        if (n == 24) rx_valid = 1'b0;
        ex = ex + 1;
        if (ex == COLS) begin ex = 0; ey = ey + 1; end
        n++;
        @(negedge clk);
      end
      chk("R10 walk length", n, COLS * BANKS);
      chk("R10 walk order and zero data", bad, 0);
    end
    chk("R10 busy cleared", 32'(busy), 0);
    chk("R10 host x kept", obs(S_X), 7);
    chk("R10 host y kept", obs(S_Y), 2);
    chk("R10 command blocked while busy", obs(S_PDV), 0);
    chk("R10 no write when idle", 32'(ram_we), 0);

    // R11 reset aborts a walk
    send(1'b0, 8'h03);
    repeat (10) @(negedge clk);
    chk("R11 walking before reset", 32'(busy), 1);
    rst_n = 1'b0;
    #1;
    chk("R11 busy dropped", 32'(busy), 0);
    chk("R11 write dropped", 32'(ram_we), 0);
    do_reset();
    chk_defaults("R11 R1");

    // R5 strap low
    ext_mode = 1'b0;
    do_reset();
    send(1'b0, 8'h24);
    chk("R5 page 2 refused", obs(S_HP), 0);
    chk("R5 refused fn-set keeps pd", obs(S_PDV), 2);
    send(1'b0, 8'h22);
    chk("R5 page 1 allowed", obs(S_HP), 1);
    send(1'b0, 8'h05);
    chk("R5 page 1 tc", obs(S_TC), 1);
    ext_mode = 1'b1;
    do_reset();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule